// File: doc/BRIEF.md
# Mode-Gated Shared Microcode RAM with Signature Walker

This block is a 1536 x 32-bit static RAM shared between a host bus and two read-only microcode fetch ports. In general-purpose mode the host reads and writes the array with a fixed two-cycle handshake. In emulation mode the host is locked out of the array, and either fetch port, or both in the same cycle, read it over its own bus. A host-visible control word holds the emulation flag and a stop flag. The stop flag refuses host array accesses but has no effect on the fetch ports.

A background signature walker compresses the whole array into a 32-bit multiple-input signature. Software starts it with a bit in the control word and polls a status word until the done bit is set. The walker reads the array in address order. It gives way to a host array access in any cycle where the two would collide, so the final signature depends only on the array contents.

The host controller has two states, H_IDLE and H_ACK. A request seen in H_IDLE moves it to H_ACK. H_ACK always returns to H_IDLE on the next edge.

The walker has three states, S_IDLE, S_WALK and S_DONE. A start pulse moves it from any state to S_WALK. S_WALK moves to S_DONE once it has folded the last address. S_DONE holds until the next start.

Top module: `shared_ucode_ram`

## Requirements
- R1: With `host_sel`=0 the host reads and writes 32-bit array word `host_waddr` (byte address bits [12:2]); a read returns the last value written to that word.
- R2: A request seen while idle raises `host_ack` for exactly one cycle, on the clock edge after the request edge, with `host_rdata` and `host_err` valid in that cycle; the host drops `host_req` on seeing `host_ack`.
- R3: Register word 0 (`host_sel`=1, `host_waddr`=0) holds emulation in bit 0 and stop in bit 1; both are 0 after reset and read back as written.
- R4: While emulation is 1, a host array access completes with `host_err`=1 and `host_rdata`=0, and a write leaves the array unchanged.
- R5: While stop is 1, host array accesses are refused the same way as in R4, while register accesses still complete with `host_err`=0.
- R6: On the edge after a fetch port's enable is high, its 32-bit lane of `uc_data` (port i at bits [32i+31:32i], address at `uc_addr`[11i+10:11i]) shows the addressed word if emulation is 1 and the address is below 1536, else 0; the lane holds while the enable is low, both ports work in the same cycle, and stop has no effect on them.
- R7: Writing 1 to bit 2 of register word 0 seeds the signature with all ones and folds words 0..1535 in order as s' = {s[30:0],0} XOR (s[31] ? 0x00400007 : 0) XOR word.
- R8: Register word 1 shows done in bit 0 and busy in bit 1; register word 2 shows the signature; done rises only after the last address is folded.
- R9: In a cycle where a host array request is taken, the walker does not advance, and the final signature equals the one with no host traffic.
- R10: A host array access with `host_waddr` >= 1536 completes with `host_err`=1 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_sel | input | 1 | 1 selects the register words, 0 the array |
| host_waddr | input | 11 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with ack |
| host_ack | output | 1 | Access complete |
| host_err | output | 1 | Access refused |
| uc_en | input | 2 | Fetch enables, one per port |
| uc_addr | input | 22 | Fetch word addresses, 11 bits per port |
| uc_data | output | 64 | Fetched words, 32 bits per port |

## Verification
The array is filled with a hashed pattern whose words all differ, so a wrong address decode shows up as a data mismatch rather than a match by coincidence. Blocked accesses are tried with stop alone, with emulation alone and with an out-of-range address. Each is followed by a read-back in the open mode, which shows whether the refused write reached the array. The fetch ports are driven together with different addresses, in both modes and with stop set, so lane swaps and stop leaking into the fetch path are visible. The signature is computed once with host array reads injected during the walk and once after one word has changed, so it shows both that stalls are harmless and that the signature depends on the data.

// File: rtl/sur_pkg.sv
package sur_pkg;
    localparam int DW = 32;
    localparam logic [31:0] MISR_TAPS = 32'h0040_0007;

    typedef enum logic {H_IDLE, H_ACK} host_st_t;
    typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} sig_st_t;

    function automatic logic [31:0] misr_next(input logic [31:0] s, input logic [31:0] d);
        return {s[30:0], 1'b0} ^ (s[31] ? MISR_TAPS : 32'h0) ^ d;
    endfunction
endpackage

// File: rtl/sur_array.sv
module sur_array #(
    parameter int DW    = 32,
    parameter int DEPTH = 1536,
    parameter int NUC   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     hr_addr,
    output logic [DW-1:0]     hr_data,
    input  logic [AW-1:0]     wk_addr,
    output logic [DW-1:0]     wk_data,
    input  logic [NUC-1:0]    uc_en,
    input  logic [NUC*AW-1:0] uc_addr,
    output logic [NUC*DW-1:0] uc_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    assign hr_data = (32'(hr_addr) < DEPTH) ? mem[hr_addr] : '0;
    assign wk_data = (32'(wk_addr) < DEPTH) ? mem[wk_addr] : '0;

    for (genvar i = 0; i < NUC; i++) begin : g_fetch
        logic [AW-1:0] a;
        logic [DW-1:0] q;
        assign a = uc_addr[i*AW +: AW];
        always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (uc_en[i])  q <= (emu && (32'(a) < DEPTH)) ? mem[a] : '0;
        end
        assign uc_data[i*DW +: DW] = q;
    end
endmodule

// File: rtl/sur_sig.sv
module sur_sig
    import sur_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stall,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] sig,
    output logic          done,
    output logic          busy
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sig_st_t st, st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: if (start) st_n = S_WALK;
            S_WALK: if (start) st_n = S_WALK;
                    else if (!stall && rd_addr == LAST) st_n = S_DONE;
            S_DONE: if (start) st_n = S_WALK;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            sig     <= '0;
        end else if (start) begin
            rd_addr <= '0;
            sig     <= '1;
        end else if (st == S_WALK && !stall) begin
            sig <= misr_next(sig, rd_data);
            if (rd_addr != LAST) rd_addr <= rd_addr + 1'b1;
        end
    end

    assign done = (st == S_DONE);
    assign busy = (st == S_WALK);
endmodule

// File: rtl/sur_ctrl.sv
module sur_ctrl
    import sur_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic          host_sel,
    input  logic [AW-1:0] host_waddr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ack,
    output logic          host_err,
    output logic          arr_we,
    input  logic [DW-1:0] arr_rdata,
    output logic          emu,
    output logic          stop,
    output logic          sig_start,
    output logic          sig_stall,
    input  logic          sig_done,
    input  logic          sig_busy,
    input  logic [DW-1:0] sig_value
);
    host_st_t st, st_n;
    logic take, arr_hit, blocked;
    logic [DW-1:0] reg_rd;
    logic [DW-1:0] rdata_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= H_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            H_IDLE: if (host_req) st_n = H_ACK;
            H_ACK:  st_n = H_IDLE;
            default: st_n = H_IDLE;
        endcase
    end

    assign take      = (st == H_IDLE) && host_req;
    assign arr_hit   = take && !host_sel;
    assign blocked   = emu || stop || !(32'(host_waddr) < DEPTH);
    assign arr_we    = arr_hit && host_we && !blocked;
    assign sig_stall = arr_hit;
    assign sig_start = take && host_sel && host_we && (host_waddr == '0) && host_wdata[2];

    always_comb begin
        reg_rd = '0;
        if (host_waddr == AW'(0))      reg_rd = {30'b0, stop, emu};
        else if (host_waddr == AW'(1)) reg_rd = {30'b0, sig_busy, sig_done};
        else if (host_waddr == AW'(2)) reg_rd = sig_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emu     <= 1'b0;
            stop    <= 1'b0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (take) begin
            if (host_sel) begin
                err_q   <= 1'b0;
                rdata_q <= host_we ? '0 : reg_rd;
                if (host_we && host_waddr == '0) begin
                    emu  <= host_wdata[0];
                    stop <= host_wdata[1];
                end
            end else begin
                err_q   <= blocked;
                rdata_q <= (blocked || host_we) ? '0 : arr_rdata;
            end
        end
    end

    assign host_ack   = (st == H_ACK);
    assign host_rdata = rdata_q;
    assign host_err   = err_q;
endmodule

// File: rtl/shared_ucode_ram.sv
module shared_ucode_ram
    import sur_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int NUC   = 2,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [AW-1:0]     host_waddr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_ack,
    output logic              host_err,
    input  logic [NUC-1:0]    uc_en,
    input  logic [NUC*AW-1:0] uc_addr,
    output logic [NUC*DW-1:0] uc_data
);
    logic          arr_we, emu, stop, sig_start, sig_stall, sig_done, sig_busy;
    logic [DW-1:0] arr_rdata, wk_data, sig_value;
    logic [AW-1:0] walk_addr;

    sur_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk, .rst_n, .host_req, .host_we, .host_sel, .host_waddr, .host_wdata,
        .host_rdata, .host_ack, .host_err, .arr_we, .arr_rdata, .emu, .stop,
        .sig_start, .sig_stall, .sig_done, .sig_busy, .sig_value
    );

    sur_array #(.DW(DW), .DEPTH(DEPTH), .NUC(NUC), .AW(AW)) u_arr (
        .clk, .rst_n, .emu, .wr_en(arr_we), .wr_addr(host_waddr), .wr_data(host_wdata),
        .hr_addr(host_waddr), .hr_data(arr_rdata), .wk_addr(walk_addr), .wk_data(wk_data),
        .uc_en, .uc_addr, .uc_data
    );

    sur_sig #(.DEPTH(DEPTH), .AW(AW)) u_sig (
        .clk, .rst_n, .start(sig_start), .stall(sig_stall), .rd_data(wk_data),
        .rd_addr(walk_addr), .sig(sig_value), .done(sig_done), .busy(sig_busy)
    );
endmodule

// File: rtl/sur_chk.sv
module sur_chk #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_req,
    input logic          host_sel,
    input logic          host_ack,
    input logic          host_err,
    input logic [31:0]   host_rdata,
    input logic          emu,
    input logic          sig_stall,
    input logic          sig_busy,
    input logic          sig_done,
    input logic [31:0]   sig_value,
    input logic [AW-1:0] walk_addr
);
    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> host_ack);
    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    // R4
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_err) |-> (host_rdata == 32'h0));
    // R4
    emu_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack && !host_sel && emu) |=> host_err);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_busy && sig_stall) |=> $stable(sig_value));
    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_done) |-> (32'(walk_addr) == DEPTH - 1));
endmodule

bind shared_ucode_ram sur_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk, .rst_n, .host_req, .host_sel, .host_ack, .host_err, .host_rdata,
    .emu, .sig_stall, .sig_busy, .sig_done, .sig_value, .walk_addr
);

// File: tb/sim_shared_ucode_ram.sv
module sim_shared_ucode_ram;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1536;

    logic        clk = 0, rst_n = 0;
    logic        host_req = 0, host_we = 0, host_sel = 0;
    logic [10:0] host_waddr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        host_ack, host_err;
    logic [1:0]  uc_en = 0;
    logic [21:0] uc_addr = 0;
    logic [63:0] uc_data;

    shared_ucode_ram u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] mem_m [DEPTH];
    bit emu_m = 0, stop_m = 0;
    logic [31:0] uc_exp [2] = '{32'h0, 32'h0};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    // reference model for the fetch ports (R6), updated at every edge
    always @(posedge clk) begin
        if (!rst_n) uc_exp = '{32'h0, 32'h0};
        else for (int i = 0; i < 2; i++) begin
            int a;
            a = int'(uc_addr[i*11 +: 11]);
            if (uc_en[i]) uc_exp[i] = (emu_m && a < DEPTH) ? mem_m[a] : 32'h0;
        end
    end
    always @(negedge clk) begin
        if (rst_n) for (int i = 0; i < 2; i++)
            chk(uc_data[i*32 +: 32] === uc_exp[i], "R6 fetch lane", 64'(uc_data[i*32 +: 32]), 64'(uc_exp[i]));
    end

    // one host transfer; R2 timing checked on each
    task automatic host_op(input bit we, input bit sel, input int a, input logic [31:0] wd,
                           output logic [31:0] rd, output logic er);
        @(negedge clk);
        host_req = 1; host_we = we; host_sel = sel; host_waddr = 11'(a); host_wdata = wd;
        chk(host_ack === 1'b0, "R2 ack low at request", 64'(host_ack), 64'd0);
        @(negedge clk);
        chk(host_ack === 1'b1, "R2 ack one cycle after request", 64'(host_ack), 64'd1);
        rd = host_rdata; er = host_err;
        host_req = 0;
        if (sel && we && a == 0) begin emu_m = wd[0]; stop_m = wd[1]; end
        if (!sel && we && !(emu_m || stop_m) && a < DEPTH) mem_m[a] = wd;
    endtask

    task automatic arr_access(input bit we, input int a, input logic [31:0] wd, input string tag);
        logic [31:0] rd; logic er; bit blk; logic [31:0] exp;
        blk = emu_m || stop_m || a >= DEPTH;
        exp = (blk || we) ? 32'h0 : mem_m[a];
        host_op(we, 0, a, wd, rd, er);
        chk(er === blk, {tag, " err"}, 64'(er), 64'(blk));
        chk(rd === exp, {tag, " data"}, 64'(rd), 64'(exp));
    endtask

    task automatic reg_read(input int a, output logic [31:0] rd);
        logic er;
        host_op(0, 1, a, 32'h0, rd, er);
        chk(er === 1'b0, "R5 register access not refused", 64'(er), 64'd0);
    endtask

    task automatic reg_write(input logic [31:0] wd);
        logic [31:0] rd; logic er;
        host_op(1, 1, 0, wd, rd, er);
    endtask

    function automatic logic [31:0] model_sig();
        logic [31:0] s = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++)
            s = {s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0) ^ mem_m[i];
        return s;
    endfunction

    task automatic run_walk(input bit inject, input string tag);
        logic [31:0] rd; int polls = 0;
        reg_write(32'h4);
        reg_read(1, rd);
        chk(rd[1:0] === 2'b10, "R8 busy set, done clear after start", 64'(rd), 64'h2);
        if (inject) for (int k = 0; k < 20; k++) arr_access(0, k * 37, 32'h0, "R9 host read during walk");
        do begin reg_read(1, rd); polls++; end while (!rd[0] && polls < 5000);
        chk(rd[1:0] === 2'b01, "R8 done set, busy clear", 64'(rd), 64'h1);
        reg_read(2, rd);
        chk(rd === model_sig(), tag, 64'(rd), 64'(model_sig()));
    endtask

    task automatic set_uc(input bit [1:0] en, input int a0, input int a1);
        @(negedge clk);
        uc_en = en; uc_addr = {11'(a1), 11'(a0)};
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(host_ack === 1'b0, "R2 ack low after reset", 64'(host_ack), 64'd0);
        reg_read(0, rd);
        chk(rd === 32'h0, "R3 control word resets to zero", 64'(rd), 64'h0);

        // R1 fill with distinct pattern, read back samples
        for (int i = 0; i < DEPTH; i++) arr_access(1, i, 32'(i) * 32'h9E37_79B9 ^ 32'(i << 3), "R1 fill write");
        for (int i = 0; i < DEPTH; i += 97) arr_access(0, i, 32'h0, "R1 read back");
        arr_access(0, DEPTH - 1, 32'h0, "R1 read last word");

        // R10 out of range
        arr_access(0, 1600, 32'h0, "R10 out-of-range read");
        arr_access(1, 2047, 32'h1234_5678, "R10 out-of-range write");

        // R5 stop refuses host array access
        reg_write(32'h2);
        reg_read(0, rd);
        chk(rd === 32'h2, "R3 stop reads back", 64'(rd), 64'h2);
        arr_access(1, 5, 32'hDEAD_BEEF, "R5 write refused under stop");
        arr_access(0, 5, 32'h0, "R5 read refused under stop");
        set_uc(2'b11, 10, 20);
        set_uc(2'b00, 0, 0);
        reg_write(32'h0);
        arr_access(0, 5, 32'h0, "R5 word unchanged after refused write");

        // R4 emulation mode, R6 both fetch ports
        reg_write(32'h1);
        reg_read(0, rd);
        chk(rd === 32'h1, "R3 emulation reads back", 64'(rd), 64'h1);
        arr_access(1, 7, 32'hCAFE_F00D, "R4 write refused in emulation");
        arr_access(0, 7, 32'h0, "R4 read refused in emulation");
        set_uc(2'b11, 7, 100);
        set_uc(2'b01, 1535, 200);
        set_uc(2'b10, 3, 1600);
        set_uc(2'b00, 9, 9);
        reg_write(32'h3);
        set_uc(2'b11, 300, 301);
        set_uc(2'b00, 0, 0);
        reg_write(32'h0);
        arr_access(0, 7, 32'h0, "R4 word unchanged after refused write");

        // R7/R9 signature with host traffic, then after a change
        run_walk(1, "R7 R9 signature with stalls");
        arr_access(1, 800, 32'h0BAD_F00D, "R1 modify word");
        run_walk(0, "R7 signature after change");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule